// File: doc/BRIEF.md
# Register Hazard Scoreboard

This block keeps an ordered record of the destination registers belonging to instructions that have left the dispatch stage and have not yet committed. Dispatch logic writes one record per dispatched instruction through the insert port. A record holds an optional destination tag, so an instruction that writes no register still takes a slot. When the instruction at the end of the pipeline commits, the commit stage retires the oldest record through the remove port.

Three combinational probe ports compare the live records with the incoming instruction's two source operands and its destination. A hit on a source probe is a read-after-write hazard. A hit on the destination probe is a write-after-write hazard. The block raises a single stall output if any of the three probes hits. The probes follow pipelined ordering. A record retiring in the same cycle is already excluded from the compare, so an instruction whose result is visible to the register read causes no stall. A record inserted in the same cycle is not seen until the next cycle.

The depth is a parameter. One slot suits a single stage beyond fetch, and two slots suit two such stages. Illegal requests are dropped, and each one is reported by a one-cycle error pulse.

Top module: `hzd_scoreboard`

## Requirements
- R1: After synchronous reset the scoreboard is empty: `sb_empty`=1, `sb_full`=0, `sb_count`=0, no probe hits and `sb_err`=0.
- R2: Each accepted insert takes one slot, whether or not its destination tag is valid. `sb_count` counts the occupied slots, and `sb_full` is 1 when `sb_count` equals DEPTH.
- R3: A probe hits a record only if the probe's valid bit and the record's valid bit are both 1 and the 5-bit indices are equal. A record with an invalid tag never hits.
- R4: `hit_src_a`, `hit_src_b` and `hit_dst` each report a hit on their own probe. `stall` is the OR of the three.
- R5: A remove retires the oldest record. Younger records, including ones with the same index, keep hitting.
- R6: While `rem_en` is 1 and the scoreboard is not empty, the oldest record is already excluded from every probe in that same cycle.
- R7: A record inserted in a cycle does not affect probe results in that cycle. It is first seen in the next cycle.
- R8: An insert while full is accepted if a legal remove happens in the same cycle. The count then stays at DEPTH.
- R9: An insert while full with no remove is dropped: contents and count are unchanged, and `sb_err` is 1 in the following cycle.
- R10: A remove while empty is dropped, and `sb_err` is 1 in the following cycle. An insert in that same cycle is still accepted.
- R11: Oldest-first order survives the storage pointers wrapping round the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Insert a record for a dispatched instruction |
| ins_dst_vld | input | 1 | Inserted instruction has a destination |
| ins_dst_idx | input | 5 | Inserted destination index |
| rem_en | input | 1 | Retire the oldest record |
| prb_a_vld | input | 1 | Source A probe valid |
| prb_a_idx | input | 5 | Source A probe index |
| prb_b_vld | input | 1 | Source B probe valid |
| prb_b_idx | input | 5 | Source B probe index |
| prb_w_vld | input | 1 | Destination probe valid |
| prb_w_idx | input | 5 | Destination probe index |
| hit_src_a | output | 1 | Read-after-write hit on source A |
| hit_src_b | output | 1 | Read-after-write hit on source B |
| hit_dst | output | 1 | Write-after-write hit on destination |
| stall | output | 1 | Any probe hit |
| sb_full | output | 1 | All slots occupied |
| sb_empty | output | 1 | No slot occupied |
| sb_count | output | $clog2(DEPTH+1) | Occupied slot count |
| sb_err | output | 1 | Pulses one cycle after a dropped request |

## Verification
On every cycle, the assertions check that the count stays within DEPTH and agrees with the per-slot occupancy bits. They also check that dropped inserts and removes leave the count unchanged and raise the error pulse. Finally, they check that an invalid probe never hits and that an empty scoreboard never stalls.

Some behaviours only the bench's scenarios can show. These are the ordering properties: which record a remove retires, the same-cycle hiding of a retiring record, the one-cycle delay before an inserted record becomes visible, and correct order after the pointers wrap.

// File: rtl/hzd_sb_pkg.sv
package hzd_sb_pkg;

    localparam int REG_IDX_W  = 5;
    localparam int NUM_PROBES = 3;

    // optional register tag: valid flag plus index
    typedef struct packed {
        logic                 vld;
        logic [REG_IDX_W-1:0] idx;
    } rtag_t;

    typedef enum logic [1:0] {
        PRB_SRC_A = 2'd0,
        PRB_SRC_B = 2'd1,
        PRB_DST   = 2'd2
    } probe_sel_e;

    // hit only when both tags are present and name the same register
    function automatic logic tag_hit(input rtag_t stored, input rtag_t probe);
        return stored.vld && probe.vld && (stored.idx == probe.idx);
    endfunction

endpackage

// File: rtl/hzd_sb_queue.sv
module hzd_sb_queue
    import hzd_sb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ins_en,
    input  rtag_t                          ins_tag,
    input  logic                           rem_en,
    output rtag_t [DEPTH-1:0]              ent,
    output logic  [DEPTH-1:0]              live,
    output logic                           full,
    output logic                           empty,
    output logic  [$clog2(DEPTH+1)-1:0]    count,
    output logic                           err
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic [DEPTH-1:0] occ_q;
    rtag_t [DEPTH-1:0] tag_q;
    logic err_q;

    logic rem_go, ins_go, bad_rem, bad_ins;
    logic [DEPTH-1:0] retire_mask;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign full   = (count_q == CNT_MAX);
    assign empty  = (count_q == '0);
    assign rem_go = rem_en && !empty;
    assign ins_go = ins_en && (!full || rem_go);
    assign bad_rem = rem_en && empty;
    assign bad_ins = ins_en && full && !rem_go;

    always_comb begin
        retire_mask = '0;
        if (rem_go) retire_mask[head_q] = 1'b1;
    end

    // retiring entry is already gone from the searches' point of view
    assign live  = occ_q & ~retire_mask;
    assign ent   = tag_q;
    assign count = count_q;
    assign err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            occ_q   <= '0;
            tag_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= bad_rem || bad_ins;
            if (rem_go) begin
                occ_q[head_q] <= 1'b0;
                head_q        <= ptr_inc(head_q);
            end
            if (ins_go) begin
                occ_q[tail_q] <= 1'b1;
                tag_q[tail_q] <= ins_tag;
                tail_q        <= ptr_inc(tail_q);
            end
            case ({ins_go, rem_go})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_MAX);

    assert_occ_agree_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(occ_q) == int'(count_q));

    assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (ins_en && full && !rem_en) |=> (count_q == $past(count_q)) && err_q);

    assert_empty_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (rem_en && empty && !ins_en) |=> (count_q == '0) && err_q);

endmodule

// File: rtl/hzd_sb_match.sv
module hzd_sb_match
    import hzd_sb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  rtag_t [DEPTH-1:0] ent,
    input  logic  [DEPTH-1:0] live,
    input  rtag_t             probe,
    output logic              hit
);
    logic [DEPTH-1:0] slot_hit;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        assign slot_hit[s] = live[s] && tag_hit(ent[s], probe);
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
    import hzd_sb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ins_en,
    input  logic                         ins_dst_vld,
    input  logic [4:0]                   ins_dst_idx,
    input  logic                         rem_en,
    input  logic                         prb_a_vld,
    input  logic [4:0]                   prb_a_idx,
    input  logic                         prb_b_vld,
    input  logic [4:0]                   prb_b_idx,
    input  logic                         prb_w_vld,
    input  logic [4:0]                   prb_w_idx,
    output logic                         hit_src_a,
    output logic                         hit_src_b,
    output logic                         hit_dst,
    output logic                         stall,
    output logic                         sb_full,
    output logic                         sb_empty,
    output logic [$clog2(DEPTH+1)-1:0]   sb_count,
    output logic                         sb_err
);
    rtag_t [DEPTH-1:0]      ent;
    logic  [DEPTH-1:0]      live;
    rtag_t [NUM_PROBES-1:0] probes;
    logic  [NUM_PROBES-1:0] hits;
    rtag_t                  ins_tag;

    assign ins_tag = '{vld: ins_dst_vld, idx: ins_dst_idx};
    assign probes[PRB_SRC_A] = '{vld: prb_a_vld, idx: prb_a_idx};
    assign probes[PRB_SRC_B] = '{vld: prb_b_vld, idx: prb_b_idx};
    assign probes[PRB_DST]   = '{vld: prb_w_vld, idx: prb_w_idx};

    hzd_sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .ins_en  (ins_en),
        .ins_tag (ins_tag),
        .rem_en  (rem_en),
        .ent     (ent),
        .live    (live),
        .full    (sb_full),
        .empty   (sb_empty),
        .count   (sb_count),
        .err     (sb_err)
    );

    for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
        hzd_sb_match #(.DEPTH(DEPTH)) u_match (
            .ent   (ent),
            .live  (live),
            .probe (probes[p]),
            .hit   (hits[p])
        );
    end

    assign hit_src_a = hits[PRB_SRC_A];
    assign hit_src_b = hits[PRB_SRC_B];
    assign hit_dst   = hits[PRB_DST];
    assign stall     = |hits;

    assert_invalid_probe_R3: assert property (@(posedge clk) disable iff (rst)
        (!prb_a_vld |-> !hit_src_a) and (!prb_b_vld |-> !hit_src_b)
        and (!prb_w_vld |-> !hit_dst));

    assert_empty_no_stall_R6: assert property (@(posedge clk) disable iff (rst)
        sb_empty |-> !stall);

endmodule

// File: tb/hzd_scoreboard_tb.sv
module hzd_scoreboard_tb;

    localparam int DEPTH = 2;

    typedef struct packed {
        logic [3:0] req;
        logic       ins;
        logic       iv;
        logic [4:0] ii;
        logic       rem;
        logic       av;
        logic [4:0] ai;
        logic       bv;
        logic [4:0] bi;
        logic       wv;
        logic [4:0] wi;
        logic       ea;
        logic       eb;
        logic       ew;
        logic       efull;
        logic       eempty;
        logic       eerr;
    } vec_t;

    localparam int NV = 16;
    // req, ins,iv,ii, rem, av,ai, bv,bi, wv,wi, ea,eb,ew, full,empty,err
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0,1'b0,5'd0,  1'b0, 1'b1,5'd1,  1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R1
        '{4'd7, 1'b1,1'b1,5'd5,  1'b0, 1'b1,5'd5,  1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R7
        '{4'd7, 1'b1,1'b1,5'd7,  1'b0, 1'b1,5'd5,  1'b1,5'd7, 1'b1,5'd5,  1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0}, // R7 R4
        '{4'd4, 1'b0,1'b0,5'd0,  1'b0, 1'b1,5'd7,  1'b1,5'd5, 1'b1,5'd3,  1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0}, // R4 R2
        '{4'd3, 1'b1,1'b1,5'd9,  1'b0, 1'b1,5'd5,  1'b0,5'd5, 1'b1,5'd7,  1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0}, // R3
        '{4'd9, 1'b0,1'b0,5'd0,  1'b1, 1'b1,5'd9,  1'b1,5'd5, 1'b1,5'd7,  1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1}, // R9 R6
        '{4'd5, 1'b1,1'b0,5'd7,  1'b0, 1'b1,5'd7,  1'b0,5'd0, 1'b0,5'd0,  1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R5
        '{4'd8, 1'b1,1'b1,5'd3,  1'b1, 1'b1,5'd7,  1'b0,5'd0, 1'b1,5'd7,  1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R8 R3
        '{4'd11,1'b0,1'b0,5'd0,  1'b1, 1'b1,5'd3,  1'b1,5'd7, 1'b0,5'd0,  1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R11
        '{4'd6, 1'b0,1'b0,5'd0,  1'b1, 1'b1,5'd3,  1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R6
        '{4'd10,1'b0,1'b0,5'd0,  1'b1, 1'b0,5'd0,  1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}, // R10
        '{4'd10,1'b1,1'b1,5'd12, 1'b1, 1'b1,5'd12, 1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1}, // R10
        '{4'd10,1'b1,1'b1,5'd12, 1'b0, 1'b1,5'd12, 1'b0,5'd0, 1'b1,5'd12, 1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1}, // R10 R4
        '{4'd5, 1'b0,1'b0,5'd0,  1'b1, 1'b1,5'd12, 1'b0,5'd0, 1'b0,5'd0,  1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R5
        '{4'd6, 1'b0,1'b0,5'd0,  1'b1, 1'b1,5'd12, 1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R6
        '{4'd2, 1'b0,1'b0,5'd0,  1'b0, 1'b0,5'd0,  1'b0,5'd0, 1'b0,5'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0}  // R2
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_en = 1'b0, ins_dst_vld = 1'b0, rem_en = 1'b0;
    logic [4:0] ins_dst_idx = '0;
    logic prb_a_vld = 1'b0, prb_b_vld = 1'b0, prb_w_vld = 1'b0;
    logic [4:0] prb_a_idx = '0, prb_b_idx = '0, prb_w_idx = '0;
    logic hit_src_a, hit_src_b, hit_dst, stall, sb_full, sb_empty, sb_err;
    logic [$clog2(DEPTH+1)-1:0] sb_count;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    hzd_scoreboard #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .ins_en(ins_en), .ins_dst_vld(ins_dst_vld), .ins_dst_idx(ins_dst_idx),
        .rem_en(rem_en),
        .prb_a_vld(prb_a_vld), .prb_a_idx(prb_a_idx),
        .prb_b_vld(prb_b_vld), .prb_b_idx(prb_b_idx),
        .prb_w_vld(prb_w_vld), .prb_w_idx(prb_w_idx),
        .hit_src_a(hit_src_a), .hit_src_b(hit_src_b), .hit_dst(hit_dst),
        .stall(stall), .sb_full(sb_full), .sb_empty(sb_empty),
        .sb_count(sb_count), .sb_err(sb_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ins_en = 1'b0; ins_dst_vld = 1'b0; ins_dst_idx = '0; rem_en = 1'b0;
        prb_a_vld = 1'b0; prb_b_vld = 1'b0; prb_w_vld = 1'b0;
        prb_a_idx = '0; prb_b_idx = '0; prb_w_idx = '0;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("R1", "empty", int'(sb_empty), 1);
        chk("R1", "full", int'(sb_full), 0);
        chk("R1", "count", int'(sb_count), 0);
        chk("R1", "err", int'(sb_err), 0);
        chk("R1", "stall", int'(stall), 0);

        // vector table: drive at negedge, sample 2 ns later, before the next posedge
        for (int v = 0; v < NV; v++) begin
            string rq;
            @(negedge clk);
            ins_en = VECS[v].ins; ins_dst_vld = VECS[v].iv; ins_dst_idx = VECS[v].ii;
            rem_en = VECS[v].rem;
            prb_a_vld = VECS[v].av; prb_a_idx = VECS[v].ai;
            prb_b_vld = VECS[v].bv; prb_b_idx = VECS[v].bi;
            prb_w_vld = VECS[v].wv; prb_w_idx = VECS[v].wi;
            #2;
            rq = $sformatf("R%0d vec%0d", VECS[v].req, v);
            chk(rq, "hit_src_a", int'(hit_src_a), int'(VECS[v].ea));
            chk(rq, "hit_src_b", int'(hit_src_b), int'(VECS[v].eb));
            chk(rq, "hit_dst", int'(hit_dst), int'(VECS[v].ew));
            chk(rq, "stall(R4)", int'(stall),
                int'(VECS[v].ea | VECS[v].eb | VECS[v].ew));
            chk(rq, "full", int'(sb_full), int'(VECS[v].efull));
            chk(rq, "empty", int'(sb_empty), int'(VECS[v].eempty));
            chk(rq, "err", int'(sb_err), int'(VECS[v].eerr));
        end

        // R2: count follows inserts, invalid-destination records included
        @(negedge clk);
        idle_inputs();
        ins_en = 1'b1; ins_dst_vld = 1'b0;
        @(negedge clk);
        #2;
        chk("R2", "count after 1 insert", int'(sb_count), 1);
        ins_en = 1'b1; ins_dst_vld = 1'b1; ins_dst_idx = 5'd31;
        @(negedge clk);
        ins_en = 1'b0;
        #2;
        chk("R2", "count after 2 inserts", int'(sb_count), 2);
        chk("R2", "full at DEPTH", int'(sb_full), 1);
        // R8: insert plus remove while full keeps count at DEPTH
        ins_en = 1'b1; ins_dst_vld = 1'b1; ins_dst_idx = 5'd17; rem_en = 1'b1;
        @(negedge clk);
        idle_inputs();
        prb_a_vld = 1'b1; prb_a_idx = 5'd17;
        prb_b_vld = 1'b1; prb_b_idx = 5'd31;
        #2;
        chk("R8", "count stays full", int'(sb_count), 2);
        chk("R8", "new record visible", int'(hit_src_a), 1);
        chk("R11", "older record kept", int'(hit_src_b), 1);
        chk("R8", "no error", int'(sb_err), 0);

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", "empty after reset", int'(sb_empty), 1);
        chk("R1", "no hit after reset", int'(stall), 0);

        @(negedge clk);
        finish_run();
    end

endmodule